// File: doc/BRIEF.md
# Reference Pre-Divider to 8 kHz

This block conditions one or more reference clocks before they reach a phase comparator. Each reference is sampled in the system clock domain, synchronised, and reduced to a one-cycle comparison pulse. Each channel runs in one of three modes. In pass-through mode every qualifying reference edge yields a pulse. In automatic mode the divide ratio is looked up from a spot-frequency code, so that the pulse rate becomes 8 kHz. In manual mode the ratio is N+1, where N is a single value shared by all channels and written as a high/low register pair.

A per-channel polarity bit picks whether rising or falling reference edges are counted. Ratio, mode validity and polarity are captured only when the running count reaches its terminal value. A configuration change therefore never shortens or stretches a division period already in progress. The phase detector and loop filter that consume the pulses are outside this block.

Top module: `refdiv_8k`

## Requirements
- R1: While rst_n is low, and after release until a qualifying reference edge has been counted, every bit of pulse_o is 0.
- R2: Pass-through mode (mode field bits 1 and 0 both 0) yields one pulse per qualifying reference edge. The pulse is high in the third clock cycle after the edge is first sampled.
- R3: Polarity bit 0 counts rising reference edges and polarity bit 1 counts falling ones; edges of the other direction produce nothing.
- R4: Automatic mode (mode bit 0 set, bit 1 clear) divides by a ratio chosen by the 4-bit spot code: 0 gives 256 (2.048 MHz), 1 gives 193 (1.544 MHz), 2 gives 810 (6.48 MHz), 3 gives 2430 (19.44 MHz), 4 gives 3240 (25.92 MHz), 5 gives 4860 (38.88 MHz), 6 gives 6480 (51.84 MHz) and 7 gives 9720 (77.76 MHz). The first pulse follows the ratio-th edge.
- R5: In automatic mode spot codes 8 to 15 are unsupported and the channel emits no pulses.
- R6: Manual mode (mode bit 1 set) divides by N+1. N = {n_hi_i, n_lo_i} is shared by all channels and valid from 1 to 12499.
- R7: In manual mode, N = 0 or N above 12499 stops the channel from emitting pulses.
- R8: When both mode bits are set, manual division applies and the spot code is ignored.
- R9: A change of mode, spot code, N or polarity on a running channel takes effect only at the next terminal count. The period in progress completes with the old ratio.
- R10: Each comparison pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the references |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | NUM_REFS | Reference clock per channel |
| mode_i | input | 2*NUM_REFS | Per channel: bit 1 manual enable, bit 0 automatic enable |
| spot_i | input | 4*NUM_REFS | Per-channel spot-frequency code |
| pol_i | input | NUM_REFS | Per-channel edge select, 1 = falling |
| n_hi_i | input | N_W-N_LO_W | Upper part of the shared N value |
| n_lo_i | input | N_LO_W | Lower part of the shared N value |
| pulse_o | output | NUM_REFS | One-cycle comparison pulse per channel |

## Verification
The bench builds the block with its defaults: two channels, a 14-bit N split 6/8, N limit 12499 and a two-stage synchroniser. With these values the largest manual ratio (12500) and the largest spot ratio (9720) can be run end to end, at one reference edge every two clocks. Two channels show that the shared N reaches both channels while mode and polarity stay per-channel. Randomised small N values and the two smallest spot ratios check the pulse count as floor(edges/ratio) over many lengths.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   localparam int SPOT_W  = 4;
   localparam int SPOT_RW = 14;

   typedef struct packed {
      logic               ok;
      logic [SPOT_RW-1:0] ratio;
   } spot_ratio_t;

   // divide ratio that brings a spot frequency down to 8 kHz
   function automatic spot_ratio_t spot_lookup(input logic [SPOT_W-1:0] code);
      spot_ratio_t r;
      r.ok = 1'b1;
      unique case (code)
         4'd0:    r.ratio = SPOT_RW'(256);
         4'd1:    r.ratio = SPOT_RW'(193);
         4'd2:    r.ratio = SPOT_RW'(810);
         4'd3:    r.ratio = SPOT_RW'(2430);
         4'd4:    r.ratio = SPOT_RW'(3240);
         4'd5:    r.ratio = SPOT_RW'(4860);
         4'd6:    r.ratio = SPOT_RW'(6480);
         4'd7:    r.ratio = SPOT_RW'(9720);
         default: begin
            r.ok    = 1'b0;
            r.ratio = SPOT_RW'(1);
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/refdiv_edge.sv
module refdiv_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   input  logic fall_sel,
   output logic edge_o
);
   localparam int TAP = SYNC_STAGES - 1;

   logic [SYNC_STAGES:0] sh_q;
   logic                 level, hist;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-1:0], ref_i};
   end

   assign level  = sh_q[TAP];
   assign hist   = sh_q[SYNC_STAGES];
   assign edge_o = fall_sel ? (hist & ~level) : (level & ~hist);
endmodule

// File: rtl/refdiv_ratio.sv
module refdiv_ratio
   import refdiv_pkg::*;
#(
   parameter int N_W   = 14,
   parameter int N_MAX = 12499,
   parameter int CNT_W = 14
) (
   input  logic [1:0]        mode,
   input  logic [SPOT_W-1:0] spot,
   input  logic [N_W-1:0]    n_val,
   output logic [CNT_W-1:0]  ratio,
   output logic              ok
);
   spot_ratio_t sr;
   logic        n_in_range;

   assign sr         = spot_lookup(spot);
   assign n_in_range = (n_val != '0) && (32'(n_val) <= N_MAX);

   always_comb begin
      if (mode[1]) begin                 // manual wins over automatic
         ok    = n_in_range;
         ratio = CNT_W'(n_val) + CNT_W'(1);
      end else if (mode[0]) begin
         ok    = sr.ok;
         ratio = CNT_W'(sr.ratio);
      end else begin
         ok    = 1'b1;
         ratio = CNT_W'(1);
      end
   end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_stb,
   input  logic [CNT_W-1:0] cfg_ratio,
   input  logic             cfg_ok,
   input  logic             cfg_pol,
   output logic             act_pol,
   output logic             pulse_o
);
   logic [CNT_W-1:0] cnt, act_ratio;
   logic             act_valid;
   logic             at_term;

   assign at_term = (cnt == act_ratio - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         act_ratio <= CNT_W'(1);
         act_valid <= 1'b0;
         act_pol   <= 1'b0;
         pulse_o   <= 1'b0;
      end else begin
         pulse_o <= 1'b0;
         if (!act_valid) begin
            cnt       <= '0;
            act_ratio <= cfg_ratio;
            act_valid <= cfg_ok;
            act_pol   <= cfg_pol;
         end else if (edge_stb) begin
            if (at_term) begin
               pulse_o   <= 1'b1;
               cnt       <= '0;
               act_ratio <= cfg_ratio;
               act_valid <= cfg_ok;
               act_pol   <= cfg_pol;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/refdiv_8k.sv
module refdiv_8k
   import refdiv_pkg::*;
#(
   parameter int NUM_REFS    = 2,
   parameter int N_W         = 14,
   parameter int N_LO_W      = 8,
   parameter int N_MAX       = 12499,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_REFS-1:0]        ref_in,
   input  logic [2*NUM_REFS-1:0]      mode_i,
   input  logic [SPOT_W*NUM_REFS-1:0] spot_i,
   input  logic [NUM_REFS-1:0]        pol_i,
   input  logic [N_W-N_LO_W-1:0]      n_hi_i,
   input  logic [N_LO_W-1:0]          n_lo_i,
   output logic [NUM_REFS-1:0]        pulse_o
);
   localparam int N_CW  = $clog2(N_MAX + 2);
   localparam int CNT_W = (N_CW > SPOT_RW) ? N_CW : SPOT_RW;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("refdiv_8k: SYNC_STAGES must be at least 2");
   end
   if (N_LO_W >= N_W) begin : g_bad_split
      $error("refdiv_8k: N_LO_W must be below N_W");
   end
   if (N_MAX < 1 || N_MAX >= (2 ** N_W)) begin : g_bad_nmax
      $error("refdiv_8k: N_MAX must fit in N_W bits");
   end
   if (NUM_REFS < 1) begin : g_bad_refs
      $error("refdiv_8k: NUM_REFS must be positive");
   end

   logic [N_W-1:0] n_shared;
   assign n_shared = {n_hi_i, n_lo_i};

   for (genvar c = 0; c < NUM_REFS; c++) begin : g_ch
      logic             edge_stb, act_pol, cfg_ok;
      logic [CNT_W-1:0] cfg_ratio;

      refdiv_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .ref_i    (ref_in[c]),
         .fall_sel (act_pol),
         .edge_o   (edge_stb)
      );

      refdiv_ratio #(.N_W(N_W), .N_MAX(N_MAX), .CNT_W(CNT_W)) u_ratio (
         .mode  (mode_i[2*c +: 2]),
         .spot  (spot_i[SPOT_W*c +: SPOT_W]),
         .n_val (n_shared),
         .ratio (cfg_ratio),
         .ok    (cfg_ok)
      );

      refdiv_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .edge_stb  (edge_stb),
         .cfg_ratio (cfg_ratio),
         .cfg_ok    (cfg_ok),
         .cfg_pol   (pol_i[c]),
         .act_pol   (act_pol),
         .pulse_o   (pulse_o[c])
      );
   end
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
   parameter int CNT_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             edge_stb,
   input logic             pulse_o,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_ratio,
   input logic             act_valid
);
   p_pulse_after_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> $past(edge_stb))
      else $error("pulse without a preceding edge");

   p_silent_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(act_valid) |-> !pulse_o)
      else $error("pulse from an invalid configuration");

   p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> (cnt < act_ratio))
      else $error("count beyond ratio");

   p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && $past(act_valid) && !pulse_o) |-> $stable(act_ratio))
      else $error("ratio changed mid-period");

   p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o)
      else $error("pulse wider than one cycle");
endmodule

bind refdiv_counter refdiv_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .edge_stb  (edge_stb),
   .pulse_o   (pulse_o),
   .cnt       (cnt),
   .act_ratio (act_ratio),
   .act_valid (act_valid)
);

// File: tb/refdiv_8k_tb_top.sv
`timescale 1ns/1ps
module refdiv_8k_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_in = '0;
   logic [3:0] mode_i = '0;
   logic [7:0] spot_i = '0;
   logic [1:0] pol_i = '0;
   logic [5:0] n_hi_i = '0;
   logic [7:0] n_lo_i = '0;
   logic [1:0] pulse_o;

   int checks = 0, errors = 0;
   int pcnt0 = 0, pcnt1 = 0;
   int cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   refdiv_8k dut_i (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mode_i(mode_i),
      .spot_i(spot_i), .pol_i(pol_i), .n_hi_i(n_hi_i), .n_lo_i(n_lo_i),
      .pulse_o(pulse_o)
   );

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         pcnt0 = 0;
         pcnt1 = 0;
      end else begin
         pcnt0 += int'(pulse_o[0]);
         pcnt1 += int'(pulse_o[1]);
      end
   end

   initial begin
      wait (cyc > 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 190000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic int exp_ratio(input int mode, input int code, input int n);
      if (mode >= 2) return (n >= 1 && n <= 12499) ? n + 1 : 0;
      if (mode == 1) begin
         case (code)
            0: return 256;   1: return 193;   2: return 810;   3: return 2430;
            4: return 3240;  5: return 4860;  6: return 6480;  7: return 9720;
            default: return 0;
         endcase
      end
      return 1;
   endfunction

   function automatic int exp_pulses(input int edges, input int ratio);
      return (ratio == 0) ? 0 : edges / ratio;
   endfunction

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_ch(input int ch, input int mode, input int code, input int pol);
      mode_i[2*ch +: 2] = 2'(mode);
      spot_i[4*ch +: 4] = 4'(code);
      pol_i[ch]         = 1'(pol);
   endtask

   task automatic set_n(input int n);
      n_hi_i = 6'(n >> 8);
      n_lo_i = 8'(n);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n  = 1'b0;
      ref_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic run_edges(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ref_in = 2'b11;
         @(negedge clk) ref_in = 2'b00;
      end
      repeat (5) @(negedge clk);
   endtask

   initial begin
      int r0, r1, m;
      void'($urandom(32'h5eed_8001));

      // R1: reset state
      set_ch(0, 0, 0, 0); set_ch(1, 0, 0, 0); set_n(3);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      ref_in = 2'b11;
      repeat (4) @(negedge clk);
      check_eq("R1 pulse in reset", int'(pulse_o), 0);
      ref_in = 2'b00;
      do_reset();
      repeat (6) @(negedge clk);
      check_eq("R1 no pulse before edge ch0", pcnt0, 0);
      check_eq("R1 no pulse before edge ch1", pcnt1, 0);

      // R2 / R3 / R10: latency and polarity, pass-through
      set_ch(0, 0, 0, 0); set_ch(1, 0, 0, 1);
      do_reset();
      ref_in = 2'b11;
      @(negedge clk); check_eq("R2 latency 1", int'(pulse_o[0]), 0);
      @(negedge clk); check_eq("R2 latency 2", int'(pulse_o[0]), 0);
      @(negedge clk); check_eq("R2 latency 3", int'(pulse_o[0]), 1);
      @(negedge clk); check_eq("R10 width", int'(pulse_o[0]), 0);
      repeat (3) @(negedge clk);
      check_eq("R3 falling ignores rise", pcnt1, 0);
      ref_in = 2'b00;
      @(negedge clk); @(negedge clk);
      check_eq("R3 fall latency 2", int'(pulse_o[1]), 0);
      @(negedge clk); check_eq("R3 fall latency 3", int'(pulse_o[1]), 1);
      @(negedge clk); check_eq("R10 width fall", int'(pulse_o[1]), 0);
      check_eq("R3 rising ignores fall", pcnt0, 1);

      do_reset();
      run_edges(37);
      check_eq("R2 count ch0", pcnt0, 37);
      check_eq("R2 count ch1", pcnt1, 37);

      // R4: every supported spot ratio, ch0 automatic
      for (int c = 0; c < 8; c++) begin
         r0 = exp_ratio(1, c, 0);
         set_ch(0, 1, c, c % 2); set_ch(1, 0, 0, 0);
         do_reset();
         run_edges(r0 - 1);
         check_eq($sformatf("R4 code %0d before terminal", c), pcnt0, 0);
         run_edges(1);
         check_eq($sformatf("R4 code %0d at terminal", c), pcnt0, 1);
      end

      // R5: unsupported codes
      set_ch(0, 1, 8, 0); set_ch(1, 1, 15, 1);
      do_reset();
      run_edges(300);
      check_eq("R5 code 8 silent", pcnt0, 0);
      check_eq("R5 code 15 silent", pcnt1, 0);

      // R6: manual, shared N
      set_n(249); set_ch(0, 2, 0, 0); set_ch(1, 2, 7, 1);
      do_reset();
      run_edges(750);
      check_eq("R6 N=249 ch0", pcnt0, 3);
      check_eq("R6 N=249 shared ch1", pcnt1, 3);
      set_n(12499); set_ch(0, 1, 7, 0); set_ch(1, 2, 0, 0);
      do_reset();
      run_edges(9720);
      check_eq("R4 ratio 9720", pcnt0, 1);
      check_eq("R6 N=12499 before terminal", pcnt1, 0);
      run_edges(2780);
      check_eq("R6 N=12499 at terminal", pcnt1, 1);

      // R7: out-of-range N
      set_n(0); set_ch(0, 2, 0, 0); set_ch(1, 0, 0, 0);
      do_reset();
      run_edges(200);
      check_eq("R7 N=0 silent", pcnt0, 0);
      check_eq("R7 other channel runs", pcnt1, 200);
      set_n(12500);
      do_reset();
      run_edges(200);
      check_eq("R7 N=12500 silent", pcnt0, 0);

      // R8: manual over automatic
      set_n(3); set_ch(0, 3, 0, 0);
      do_reset();
      run_edges(8);
      check_eq("R8 manual priority", pcnt0, 2);

      // R9: mid-period change
      set_n(3); set_ch(0, 2, 0, 0);
      do_reset();
      run_edges(2);
      set_n(9);
      run_edges(2);
      check_eq("R9 old ratio completes", pcnt0, 1);
      run_edges(9);
      check_eq("R9 new ratio pending", pcnt0, 1);
      run_edges(1);
      check_eq("R9 new ratio applied", pcnt0, 2);

      // R6 / R4: constrained random
      for (int it = 0; it < 12; it++) begin
         int n, code;
         n    = 1 + int'($urandom % 40);
         code = int'($urandom % 2);
         m    = 50 + int'($urandom % 500);
         set_n(n);
         set_ch(0, 2, int'($urandom % 16), int'($urandom % 2));
         set_ch(1, 1, code, int'($urandom % 2));
         r0 = exp_ratio(2, 0, n);
         r1 = exp_ratio(1, code, 0);
         do_reset();
         run_edges(m);
         check_eq($sformatf("R6 random N=%0d edges=%0d", n, m), pcnt0, exp_pulses(m, r0));
         check_eq($sformatf("R4 random code=%0d edges=%0d", code, m), pcnt1, exp_pulses(m, r1));
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule